// File: doc/BRIEF.md
# Interrupt Line State Tracker

This block keeps, for every one of a parameterised set of interrupt inputs, a two-bit state: idle, waiting (pending), being serviced (active), or being serviced with a further request queued (active and pending). Each line is set individually to react either to the level of its input or to a rising edge on it. The raw inputs first pass through a per-line synchroniser. Software can force a line to pending, or withdraw a pending request, by giving a write strobe together with a line mask.

A fixed-priority picker presents one request and a line number to the processor. The lowest-numbered line that is enabled, pending and not active wins, and a request is only raised while no line is being serviced. The processor answers with a take handshake that starts service of a line and a return handshake that ends it. Both name the line by its number. Programmable priorities, nesting, vector fetch and register decoding are left to surrounding logic.

Top module: `irq_state_tracker`

## Requirements
- R1: After reset every line is idle and `irq_req` is low.
- R2: On an edge-mode line (`level_mode` bit 0), a rising edge of the synchronised input makes the line pending. A rising edge during service makes it active-and-pending, and the return then leaves it pending, so it is requested again.
- R3: An edge-mode line that sees no new rising edge during service goes idle on return.
- R4: On a level-mode line (`level_mode` bit 1), an asserted synchronised input makes an idle or active line pending. On return, the line stays pending only if the input is still asserted.
- R5: A clear-pending write to a level-mode line has no effect while its input is asserted. Otherwise it removes the pending request.
- R6: A clear-pending write to an edge-mode line turns pending into idle and active-and-pending into active.
- R7: A disabled line (`enable` bit 0) still becomes pending. The enable bit only decides whether it can be requested.
- R8: A set-pending write makes each masked line pending. When a set-pending and a clear-pending write hit the same line in one cycle, the clear wins.
- R9: A take for a pending line, named by its binary index on `take_id`, makes it active at the next clock edge. A take for a line that is not pending is ignored.
- R10: A return for a line that is not active is ignored.
- R11: `irq_req` is high exactly when no line is active and some line is enabled, pending and not active. `irq_id` then gives the lowest such index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | N_LINES | Raw interrupt inputs |
| level_mode | input | N_LINES | 1 = level mode, 0 = edge mode, per line |
| enable | input | N_LINES | Per-line request enable |
| set_pend_we | input | 1 | Set-pending write strobe |
| clr_pend_we | input | 1 | Clear-pending write strobe |
| pend_mask | input | N_LINES | Lines addressed by either strobe |
| take_valid | input | 1 | Processor starts service of `take_id` |
| take_id | input | ID_W | Line being taken |
| ret_valid | input | 1 | Processor ends service of `ret_id` |
| ret_id | input | ID_W | Line returning |
| irq_req | output | 1 | Request to the processor |
| irq_id | output | ID_W | Line being requested |

## Verification
A state bit stuck or wrongly set shows up at the request port in the cycle after the offending event. A lost pending bit leaves `irq_req` low where the bench expects a request. A pending bit that was not cleared raises a request after the next return. A missed active bit lets a second line be requested while another is in service. Each scenario therefore holds a line in one state, drives one stimulus, and reads `irq_req`/`irq_id` right after the next edge. Hidden states such as active-and-pending are made visible by the request that follows a return.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

   typedef enum logic [1:0] {
      LN_IDLE     = 2'b00,
      LN_PEND     = 2'b01,
      LN_ACT      = 2'b10,
      LN_ACT_PEND = 2'b11
   } line_state_e;

   function automatic line_state_e pack_state(input logic pend, input logic act);
      return line_state_e'({act, pend});
   endfunction

   function automatic logic st_pend(input line_state_e s);
      return s[0];
   endfunction

   function automatic logic st_act(input line_state_e s);
      return s[1];
   endfunction

endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic lvl_o,
   output logic rise_o
);

   logic prev_q;

   generate
      if (STAGES == 0) begin : g_bypass
         assign lvl_o = raw;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else if (STAGES == 1) chain_q <= raw;
            else chain_q <= {chain_q[STAGES-2:0], raw};
         end
         assign lvl_o = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_o;
   end

   assign rise_o = lvl_o & ~prev_q;

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
   import irq_trk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic is_level,
   input  logic lvl,
   input  logic rise,
   input  logic set_hit,
   input  logic clr_hit,
   input  logic take_req,
   input  logic ret_req,
   output logic pend_o,
   output logic act_o
);

   line_state_e state_q;
   logic pend_n, act_n, take_ok, ret_ok, hw_hit;

   assign pend_o  = st_pend(state_q);
   assign act_o   = st_act(state_q);
   assign take_ok = take_req & pend_o;
   assign ret_ok  = ret_req & act_o;
   assign hw_hit  = is_level ? (lvl & ~take_ok) : rise;

   always_comb begin
      pend_n = pend_o;
      act_n  = act_o;
      if (take_ok) begin
         pend_n = 1'b0;
         act_n  = 1'b1;
      end
      if (ret_ok) begin
         act_n = 1'b0;
         if (is_level) pend_n = lvl;
      end
      if (hw_hit)  pend_n = 1'b1;
      if (set_hit) pend_n = 1'b1;
      if (clr_hit && !(is_level && lvl)) pend_n = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LN_IDLE;
      else        state_q <= pack_state(pend_n, act_n);
   end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int N_LINES = 8,
   parameter int ID_W    = 3
) (
   input  logic [N_LINES-1:0] cand,
   input  logic               busy,
   output logic               req,
   output logic [ID_W-1:0]    id
);

   always_comb begin
      id = '0;
      for (int i = N_LINES - 1; i >= 0; i--) begin
         if (cand[i]) id = ID_W'(i);
      end
   end

   assign req = (|cand) & ~busy;

endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker #(
   parameter int N_LINES     = 8,
   parameter int SYNC_STAGES = 2,
   localparam int ID_W       = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] irq_in,
   input  logic [N_LINES-1:0] level_mode,
   input  logic [N_LINES-1:0] enable,
   input  logic               set_pend_we,
   input  logic               clr_pend_we,
   input  logic [N_LINES-1:0] pend_mask,
   input  logic               take_valid,
   input  logic [ID_W-1:0]    take_id,
   input  logic               ret_valid,
   input  logic [ID_W-1:0]    ret_id,
   output logic               irq_req,
   output logic [ID_W-1:0]    irq_id
);

   generate
      if (N_LINES < 1 || N_LINES > 256) begin : g_bad_lines
         $error("irq_state_tracker: N_LINES out of range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("irq_state_tracker: SYNC_STAGES out of range");
      end
   endgenerate

   logic [N_LINES-1:0] lvl_vec, rise_vec, pend_vec, act_vec, cand_vec;

   generate
      for (genvar g = 0; g < N_LINES; g++) begin : g_line
         logic hit_take, hit_ret;
         assign hit_take = take_valid && (take_id == ID_W'(g));
         assign hit_ret  = ret_valid  && (ret_id  == ID_W'(g));

         irq_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (irq_in[g]),
            .lvl_o  (lvl_vec[g]),
            .rise_o (rise_vec[g])
         );

         irq_line_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .is_level (level_mode[g]),
            .lvl      (lvl_vec[g]),
            .rise     (rise_vec[g]),
            .set_hit  (set_pend_we & pend_mask[g]),
            .clr_hit  (clr_pend_we & pend_mask[g]),
            .take_req (hit_take),
            .ret_req  (hit_ret),
            .pend_o   (pend_vec[g]),
            .act_o    (act_vec[g])
         );
      end
   endgenerate

   assign cand_vec = pend_vec & enable & ~act_vec;

   irq_pick #(.N_LINES(N_LINES), .ID_W(ID_W)) u_pick (
      .cand (cand_vec),
      .busy (|act_vec),
      .req  (irq_req),
      .id   (irq_id)
   );

endmodule

// File: rtl/irq_state_tracker_chk.sv
module irq_state_tracker_chk #(
   parameter int N_LINES = 8,
   parameter int ID_W    = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_LINES-1:0] level_mode,
   input logic [N_LINES-1:0] enable,
   input logic               set_pend_we,
   input logic               clr_pend_we,
   input logic [N_LINES-1:0] pend_mask,
   input logic               take_valid,
   input logic [ID_W-1:0]    take_id,
   input logic               ret_valid,
   input logic [ID_W-1:0]    ret_id,
   input logic               irq_req,
   input logic [ID_W-1:0]    irq_id,
   input logic [N_LINES-1:0] pend_vec,
   input logic [N_LINES-1:0] act_vec
);

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pend_vec == '0 && act_vec == '0 && !irq_req));

   // R11
   req_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (int'(irq_id) < N_LINES && pend_vec[irq_id] && enable[irq_id]
                   && act_vec == '0));

   // R9
   take_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_valid && int'(take_id) < N_LINES && pend_vec[take_id])
      |=> act_vec[$past(take_id)]);

   // R10
   ret_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && int'(ret_id) < N_LINES && !act_vec[ret_id]
       && !(take_valid && take_id == ret_id))
      |=> !act_vec[$past(ret_id)]);

   generate
      for (genvar g = 0; g < N_LINES; g++) begin : g_ln
         // R8
         set_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_pend_we && pend_mask[g] && !clr_pend_we) |=> pend_vec[g]);
         // R6
         clr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_pend_we && pend_mask[g] && !level_mode[g]) |=> !pend_vec[g]);
      end
   endgenerate

endmodule

bind irq_state_tracker irq_state_tracker_chk #(.N_LINES(N_LINES), .ID_W(ID_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .level_mode  (level_mode),
   .enable      (enable),
   .set_pend_we (set_pend_we),
   .clr_pend_we (clr_pend_we),
   .pend_mask   (pend_mask),
   .take_valid  (take_valid),
   .take_id     (take_id),
   .ret_valid   (ret_valid),
   .ret_id      (ret_id),
   .irq_req     (irq_req),
   .irq_id      (irq_id),
   .pend_vec    (pend_vec),
   .act_vec     (act_vec)
);

// File: tb/irq_state_tracker_test.sv
module irq_state_tracker_test;

   localparam int N = 8;
   localparam int W = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] irq_in = '0, level_mode = '0, enable = '1, pend_mask = '0;
   logic         set_pend_we = 1'b0, clr_pend_we = 1'b0;
   logic         take_valid = 1'b0, ret_valid = 1'b0;
   logic [W-1:0] take_id = '0, ret_id = '0;
   logic         irq_req;
   logic [W-1:0] irq_id;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   irq_state_tracker #(.N_LINES(N), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
      .enable(enable), .set_pend_we(set_pend_we), .clr_pend_we(clr_pend_we),
      .pend_mask(pend_mask), .take_valid(take_valid), .take_id(take_id),
      .ret_valid(ret_valid), .ret_id(ret_id), .irq_req(irq_req), .irq_id(irq_id)
   );

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_req(input string tag, input logic exp_req, input logic [W-1:0] exp_id);
      checks++;
      if (irq_req !== exp_req || (exp_req && irq_id !== exp_id)) begin
         errors++;
         $display("FAIL %s: req=%0b id=%0d, expected req=%0b id=%0d",
                  tag, irq_req, irq_id, exp_req, exp_id);
      end
   endtask

   task automatic pulse_line(input int ln);
      irq_in[ln] = 1'b1;
      wait_n(1);
      irq_in[ln] = 1'b0;
      wait_n(4);
   endtask

   task automatic do_take(input int ln);
      take_valid = 1'b1; take_id = W'(ln);
      wait_n(1);
      take_valid = 1'b0;
   endtask

   task automatic do_ret(input int ln);
      ret_valid = 1'b1; ret_id = W'(ln);
      wait_n(1);
      ret_valid = 1'b0;
   endtask

   task automatic sw_write(input logic s, input logic c, input logic [N-1:0] m);
      set_pend_we = s; clr_pend_we = c; pend_mask = m;
      wait_n(1);
      set_pend_we = 1'b0; clr_pend_we = 1'b0; pend_mask = '0;
   endtask

   task automatic t_reset;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);
      expect_req("R1 reset idle", 1'b0, '0);
   endtask

   task automatic t_edge_repeat;
      pulse_line(1);
      expect_req("R2 rising edge pends", 1'b1, 3'd1);
      do_take(1);
      expect_req("R9 take makes active", 1'b0, '0);
      pulse_line(1);
      expect_req("R2 active-and-pending not requested", 1'b0, '0);
      do_ret(1);
      expect_req("R2 return re-requests", 1'b1, 3'd1);
      do_take(1);
      do_ret(1);
      expect_req("R3 return without new edge idles", 1'b0, '0);
   endtask

   task automatic t_level;
      level_mode[3] = 1'b1;
      irq_in[3] = 1'b1;
      wait_n(4);
      expect_req("R4 asserted level pends", 1'b1, 3'd3);
      do_take(3);
      wait_n(2);
      do_ret(3);
      expect_req("R4 still asserted at return", 1'b1, 3'd3);
      sw_write(1'b0, 1'b1, 8'h08);
      expect_req("R5 clear ignored while asserted", 1'b1, 3'd3);
      irq_in[3] = 1'b0;
      wait_n(4);
      expect_req("R4 pending held after input drops", 1'b1, 3'd3);
      sw_write(1'b0, 1'b1, 8'h08);
      expect_req("R5 clear with input low", 1'b0, '0);
      irq_in[3] = 1'b1;
      wait_n(4);
      do_take(3);
      irq_in[3] = 1'b0;
      wait_n(4);
      do_ret(3);
      expect_req("R4 input low at return idles", 1'b0, '0);
      level_mode[3] = 1'b0;
   endtask

   task automatic t_edge_clear;
      pulse_line(1);
      sw_write(1'b0, 1'b1, 8'h02);
      expect_req("R6 clear pending edge line", 1'b0, '0);
      pulse_line(1);
      do_take(1);
      pulse_line(1);
      sw_write(1'b0, 1'b1, 8'h02);
      sw_write(1'b1, 1'b0, 8'h10);
      expect_req("R11 active line blocks request", 1'b0, '0);
      do_ret(1);
      expect_req("R6 active-and-pending cleared to active", 1'b1, 3'd4);
      do_take(4);
      do_ret(4);
      expect_req("R3 cleanup idle", 1'b0, '0);
   endtask

   task automatic t_disabled;
      enable = 8'hDF;
      pulse_line(5);
      expect_req("R7 disabled not requested", 1'b0, '0);
      enable = '1;
      wait_n(1);
      expect_req("R7 pended while disabled", 1'b1, 3'd5);
      do_take(5);
      do_ret(5);
   endtask

   task automatic t_sw_pend;
      sw_write(1'b1, 1'b0, 8'h44);
      expect_req("R11 lowest index wins", 1'b1, 3'd2);
      sw_write(1'b0, 1'b1, 8'h04);
      expect_req("R8 set-pending forced line 6", 1'b1, 3'd6);
      sw_write(1'b0, 1'b1, 8'h40);
      sw_write(1'b1, 1'b1, 8'h08);
      expect_req("R8 clear wins over set", 1'b0, '0);
   endtask

   task automatic t_take_ret;
      do_take(7);
      sw_write(1'b1, 1'b0, 8'h04);
      expect_req("R9 take of idle line ignored", 1'b1, 3'd2);
      do_take(2);
      sw_write(1'b1, 1'b0, 8'h40);
      do_ret(5);
      expect_req("R10 return of idle line ignored", 1'b0, '0);
      do_ret(2);
      expect_req("R11 next line after return", 1'b1, 3'd6);
      do_take(6);
      do_ret(6);
      expect_req("R11 all idle", 1'b0, '0);
   endtask

   initial begin
      t_reset();
      t_edge_repeat();
      t_level();
      t_edge_clear();
      t_disabled();
      t_sw_pend();
      t_take_ret();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule